// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out where a small 8-bit controller core fetches next after a control-flow instruction. It also reports how many execution cycles that instruction costs. The core's decoder gives it several inputs: an instruction class code, the current program counter, a signed relative offset and an absolute target. The core also supplies the 16-bit Z pointer, the address just popped from the stack, the status register, a bit-select index, a tested condition bit, and a flag that says whether the instruction after the current one is two words long.

The unit covers relative, indirect and direct jumps and calls, plain and interrupt returns, skip-on-condition instructions, and branches on a status bit. It produces the next PC, the return address the core must push for a call, a push strobe, the cycle count, and a strobe that tells the core to set the global interrupt enable. Stack storage and instruction fetch stay outside the block.

The inputs are sampled when `step_en` is high. The results are registered and appear, together with `out_vld`, after the next rising clock edge. When `step_en` is low the registered results hold.

Top module: `pc_step_unit`

## Requirements
- R1: While reset is active, and until the first accepted step after reset, `out_vld`, `next_pc`, `push_en`, `push_addr`, `cycles` and `set_ie` are all zero.
- R2: When `step_en` is low at a rising edge, `out_vld` is 0 after that edge and `next_pc`, `push_en`, `push_addr`, `cycles` and `set_ie` keep their previous values.
- R3: Relative jump (op 1) and relative call (op 4) give `next_pc` = pc + sign-extended `rel_off[11:0]` + 1, modulo 2^16. Relative jump costs 2 cycles and relative call costs 3.
- R4: Indirect jump (op 2) and indirect call (op 5) give `next_pc` = `z_ptr`. Indirect jump costs 2 cycles and indirect call costs 3.
- R5: Direct jump (op 3) and direct call (op 6) give `next_pc` = `abs_tgt`. Direct jump costs 3 cycles and direct call costs 4.
- R6: Ops 4 and 5 raise `push_en` with `push_addr` = pc + 1. Op 6 raises `push_en` with `push_addr` = pc + 2. Every other op leaves `push_en` = 0 and `push_addr` = 0.
- R7: Return (op 7) and interrupt return (op 8) give `next_pc` = `pop_addr` and cost 4 cycles. `set_ie` is 1 only after op 8 and is 0 after every other op.
- R8: Skip-if-clear (op 9) is taken when `test_bit` = 0, and skip-if-set (op 10) is taken when `test_bit` = 1. A taken skip gives pc + 3 and 3 cycles when `next_two_word` = 1, or pc + 2 and 2 cycles otherwise. A skip that is not taken gives pc + 1 and 1 cycle. Compare-skip-if-equal is issued as op 10 with the equality result on `test_bit`.
- R9: Branch-if-clear (op 11) is taken when `sreg[bit_sel]` = 0, and branch-if-set (op 12) is taken when `sreg[bit_sel]` = 1. A taken branch gives pc + sign-extended `rel_off[6:0]` + 1 and 2 cycles. A branch that is not taken gives pc + 1 and 1 cycle. The zero flag is `sreg[1]`, so branch-if-equal is op 12 with `bit_sel` = 1 and branch-if-not-equal is op 11 with `bit_sel` = 1.
- R10: Op 0 (sequential) and the unused codes 13 to 15 give pc + 1 and 1 cycle.
- R11: A step accepted at a rising edge shows its results, with `out_vld` = 1, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Accept the inputs at this edge |
| op | input | 4 | Instruction class code |
| pc | input | 16 | Current program counter |
| rel_off | input | 12 | Signed offset; branches use the low 7 bits |
| abs_tgt | input | 16 | Absolute target for direct jump or call |
| z_ptr | input | 16 | Z pointer for indirect transfers |
| pop_addr | input | 16 | Address popped from the stack |
| sreg | input | 8 | Status register |
| bit_sel | input | 3 | Status bit tested by a branch |
| test_bit | input | 1 | Condition value tested by a skip |
| next_two_word | input | 1 | The following instruction is two words long |
| out_vld | output | 1 | Results belong to a step accepted at the last edge |
| next_pc | output | 16 | Next program counter |
| push_en | output | 1 | Push `push_addr` onto the stack |
| push_addr | output | 16 | Return address for a call |
| cycles | output | 3 | Execution cycles of the instruction |
| set_ie | output | 1 | Set the global interrupt enable |

## Verification
The assertions check the following on every cycle:
- holding of the results while idle;
- the one-edge valid timing;
- return targets taken from the pop address;
- push addresses for direct calls;
- indirect targets;
- that the interrupt-enable strobe is confined to interrupt return;
- that the cycle count always lies between 1 and 4 on a valid result.

Only the bench's sweeps can show the rest:
- the sign-extended offset arithmetic, including wrap-around at both ends of the address space;
- the split between two-word and one-word skips;
- branch decisions for every status bit under several status patterns;
- the fall-back behaviour of unused class codes.

// File: rtl/pc_step_pkg.sv
package pc_step_pkg;

  typedef enum logic [3:0] {
    OP_SEQ     = 4'd0,
    OP_RJMP    = 4'd1,
    OP_IJMP    = 4'd2,
    OP_JMP     = 4'd3,
    OP_RCALL   = 4'd4,
    OP_ICALL   = 4'd5,
    OP_CALL    = 4'd6,
    OP_RET     = 4'd7,
    OP_RETI    = 4'd8,
    OP_SKIPCLR = 4'd9,
    OP_SKIPSET = 4'd10,
    OP_BRCLR   = 4'd11,
    OP_BRSET   = 4'd12
  } step_op_e;

  localparam int OP_W  = 4;
  localparam int CYC_W = 3;

  localparam logic [CYC_W-1:0] CYC_ONE   = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_TWO   = CYC_W'(2);
  localparam logic [CYC_W-1:0] CYC_THREE = CYC_W'(3);
  localparam logic [CYC_W-1:0] CYC_FOUR  = CYC_W'(4);

endpackage

// File: rtl/pc_rel_adder.sv
module pc_rel_adder #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 12
) (
  input  logic [PC_W-1:0]  base_pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  target
);

  localparam logic [PC_W-1:0] INC_ONE = PC_W'(1);

  logic [PC_W-1:0] off_ext;

  // sign-extend the offset to the PC width
  assign off_ext = PC_W'($signed(offset));
  assign target  = base_pc + off_ext + INC_ONE;

endmodule

// File: rtl/pc_cond_eval.sv
module pc_cond_eval
  import pc_step_pkg::*;
#(
  parameter int SREG_W = 8,
  localparam int SEL_W = $clog2(SREG_W)
) (
  input  logic [OP_W-1:0]   op,
  input  logic [SREG_W-1:0] sreg,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              test_bit,
  output logic              br_taken,
  output logic              skip_taken
);

  logic status_bit;

  assign status_bit = sreg[bit_sel];

  always_comb begin
    br_taken   = 1'b0;
    skip_taken = 1'b0;
    case (step_op_e'(op))
      OP_BRSET:   br_taken   = status_bit;
      OP_BRCLR:   br_taken   = ~status_bit;
      OP_SKIPSET: skip_taken = test_bit;
      OP_SKIPCLR: skip_taken = ~test_bit;
      default: begin
        br_taken   = 1'b0;
        skip_taken = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pc_step_decode.sv
module pc_step_decode
  import pc_step_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  long_tgt,
  input  logic [PC_W-1:0]  short_tgt,
  input  logic [PC_W-1:0]  abs_tgt,
  input  logic [PC_W-1:0]  z_ptr,
  input  logic [PC_W-1:0]  pop_addr,
  input  logic             br_taken,
  input  logic             skip_taken,
  input  logic             next_two_word,
  output logic [PC_W-1:0]  nxt_pc,
  output logic             nxt_push_en,
  output logic [PC_W-1:0]  nxt_push_addr,
  output logic [CYC_W-1:0] nxt_cycles,
  output logic             nxt_set_ie
);

  localparam logic [PC_W-1:0] STEP1 = PC_W'(1);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(2);
  localparam logic [PC_W-1:0] STEP3 = PC_W'(3);

  logic [PC_W-1:0] pc_p1;
  logic [PC_W-1:0] pc_p2;
  logic [PC_W-1:0] pc_p3;

  assign pc_p1 = pc + STEP1;
  assign pc_p2 = pc + STEP2;
  assign pc_p3 = pc + STEP3;

  always_comb begin
    nxt_pc        = pc_p1;
    nxt_push_en   = 1'b0;
    nxt_push_addr = '0;
    nxt_cycles    = CYC_ONE;
    nxt_set_ie    = 1'b0;
    case (step_op_e'(op))
      OP_RJMP: begin
        nxt_pc     = long_tgt;
        nxt_cycles = CYC_TWO;
      end
      OP_IJMP: begin
        nxt_pc     = z_ptr;
        nxt_cycles = CYC_TWO;
      end
      OP_JMP: begin
        nxt_pc     = abs_tgt;
        nxt_cycles = CYC_THREE;
      end
      OP_RCALL: begin
        nxt_pc        = long_tgt;
        nxt_cycles    = CYC_THREE;
        nxt_push_en   = 1'b1;
        nxt_push_addr = pc_p1;
      end
      OP_ICALL: begin
        nxt_pc        = z_ptr;
        nxt_cycles    = CYC_THREE;
        nxt_push_en   = 1'b1;
        nxt_push_addr = pc_p1;
      end
      OP_CALL: begin
        nxt_pc        = abs_tgt;
        nxt_cycles    = CYC_FOUR;
        nxt_push_en   = 1'b1;
        nxt_push_addr = pc_p2;
      end
      OP_RET: begin
        nxt_pc     = pop_addr;
        nxt_cycles = CYC_FOUR;
      end
      OP_RETI: begin
        nxt_pc     = pop_addr;
        nxt_cycles = CYC_FOUR;
        nxt_set_ie = 1'b1;
      end
      OP_SKIPCLR, OP_SKIPSET: begin
        if (skip_taken) begin
          if (next_two_word) begin
            nxt_pc     = pc_p3;
            nxt_cycles = CYC_THREE;
          end else begin
            nxt_pc     = pc_p2;
            nxt_cycles = CYC_TWO;
          end
        end
      end
      OP_BRCLR, OP_BRSET: begin
        if (br_taken) begin
          nxt_pc     = short_tgt;
          nxt_cycles = CYC_TWO;
        end
      end
      default: begin
        nxt_pc     = pc_p1;
        nxt_cycles = CYC_ONE;
      end
    endcase
  end

endmodule

// File: rtl/pc_step_unit.sv
module pc_step_unit
  import pc_step_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int REL_W  = 12,
  parameter int BR_W   = 7,
  parameter int SREG_W = 8,
  localparam int SEL_W = $clog2(SREG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [OP_W-1:0]   op,
  input  logic [PC_W-1:0]   pc,
  input  logic [REL_W-1:0]  rel_off,
  input  logic [PC_W-1:0]   abs_tgt,
  input  logic [PC_W-1:0]   z_ptr,
  input  logic [PC_W-1:0]   pop_addr,
  input  logic [SREG_W-1:0] sreg,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              test_bit,
  input  logic              next_two_word,
  output logic              out_vld,
  output logic [PC_W-1:0]   next_pc,
  output logic              push_en,
  output logic [PC_W-1:0]   push_addr,
  output logic [CYC_W-1:0]  cycles,
  output logic              set_ie
);

  // reset synchronizer: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // target computation
  logic [PC_W-1:0] long_tgt;
  logic [PC_W-1:0] short_tgt;
  logic            br_taken;
  logic            skip_taken;

  pc_rel_adder #(.PC_W(PC_W), .OFF_W(REL_W)) u_long_add (
    .base_pc (pc),
    .offset  (rel_off),
    .target  (long_tgt)
  );

  pc_rel_adder #(.PC_W(PC_W), .OFF_W(BR_W)) u_short_add (
    .base_pc (pc),
    .offset  (rel_off[BR_W-1:0]),
    .target  (short_tgt)
  );

  pc_cond_eval #(.SREG_W(SREG_W)) u_cond (
    .op         (op),
    .sreg       (sreg),
    .bit_sel    (bit_sel),
    .test_bit   (test_bit),
    .br_taken   (br_taken),
    .skip_taken (skip_taken)
  );

  logic [PC_W-1:0]  dec_pc;
  logic             dec_push_en;
  logic [PC_W-1:0]  dec_push_addr;
  logic [CYC_W-1:0] dec_cycles;
  logic             dec_set_ie;

  pc_step_decode #(.PC_W(PC_W)) u_dec (
    .op            (op),
    .pc            (pc),
    .long_tgt      (long_tgt),
    .short_tgt     (short_tgt),
    .abs_tgt       (abs_tgt),
    .z_ptr         (z_ptr),
    .pop_addr      (pop_addr),
    .br_taken      (br_taken),
    .skip_taken    (skip_taken),
    .next_two_word (next_two_word),
    .nxt_pc        (dec_pc),
    .nxt_push_en   (dec_push_en),
    .nxt_push_addr (dec_push_addr),
    .nxt_cycles    (dec_cycles),
    .nxt_set_ie    (dec_set_ie)
  );

  // next-state for the result registers, with the clock enable written out
  logic             vld_d;
  logic [PC_W-1:0]  pc_d;
  logic             push_en_d;
  logic [PC_W-1:0]  push_addr_d;
  logic [CYC_W-1:0] cycles_d;
  logic             set_ie_d;

  always_comb begin
    vld_d       = step_en;
    pc_d        = next_pc;
    push_en_d   = push_en;
    push_addr_d = push_addr;
    cycles_d    = cycles;
    set_ie_d    = set_ie;
    if (step_en) begin
      pc_d        = dec_pc;
      push_en_d   = dec_push_en;
      push_addr_d = dec_push_addr;
      cycles_d    = dec_cycles;
      set_ie_d    = dec_set_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld   <= 1'b0;
      next_pc   <= '0;
      push_en   <= 1'b0;
      push_addr <= '0;
      cycles    <= '0;
      set_ie    <= 1'b0;
    end else begin
      out_vld   <= vld_d;
      next_pc   <= pc_d;
      push_en   <= push_en_d;
      push_addr <= push_addr_d;
      cycles    <= cycles_d;
      set_ie    <= set_ie_d;
    end
  end

endmodule

// File: rtl/pc_step_chk.sv
module pc_step_chk
  import pc_step_pkg::*;
#(
  parameter int PC_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             step_en,
  input logic [OP_W-1:0]  op,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  z_ptr,
  input logic [PC_W-1:0]  pop_addr,
  input logic             out_vld,
  input logic [PC_W-1:0]  next_pc,
  input logic             push_en,
  input logic [PC_W-1:0]  push_addr,
  input logic [CYC_W-1:0] cycles,
  input logic             set_ie
);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !step_en |=> (!out_vld && $stable(next_pc) && $stable(push_en) &&
                  $stable(push_addr) && $stable(cycles) && $stable(set_ie)));

  // R11
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en |=> out_vld);

  // R7
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && (op == OP_RET || op == OP_RETI)) |=>
      (next_pc == $past(pop_addr) && cycles == CYC_FOUR));

  // R7
  ie_only_reti_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && op != OP_RETI) |=> !set_ie);

  // R6
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && op == OP_CALL) |=> (push_en && push_addr == $past(pc) + PC_W'(2)));

  // R4
  indirect_tgt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && (op == OP_IJMP || op == OP_ICALL)) |=> (next_pc == $past(z_ptr)));

  // R10
  cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_vld |-> (cycles >= CYC_ONE && cycles <= CYC_FOUR));

endmodule

bind pc_step_unit pc_step_chk #(.PC_W(PC_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .step_en    (step_en),
  .op         (op),
  .pc         (pc),
  .z_ptr      (z_ptr),
  .pop_addr   (pop_addr),
  .out_vld    (out_vld),
  .next_pc    (next_pc),
  .push_en    (push_en),
  .push_addr  (push_addr),
  .cycles     (cycles),
  .set_ie     (set_ie)
);

// File: tb/pc_step_unit_tb_top.sv
module pc_step_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [3:0]  op;
  logic [15:0] pc;
  logic [11:0] rel_off;
  logic [15:0] abs_tgt;
  logic [15:0] z_ptr;
  logic [15:0] pop_addr;
  logic [7:0]  sreg;
  logic [2:0]  bit_sel;
  logic        test_bit;
  logic        next_two_word;
  logic        out_vld;
  logic [15:0] next_pc;
  logic        push_en;
  logic [15:0] push_addr;
  logic [2:0]  cycles;
  logic        set_ie;

  int n_tests;
  int n_fail;
  int cyc_cnt;

  pc_step_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_en       (step_en),
    .op            (op),
    .pc            (pc),
    .rel_off       (rel_off),
    .abs_tgt       (abs_tgt),
    .z_ptr         (z_ptr),
    .pop_addr      (pop_addr),
    .sreg          (sreg),
    .bit_sel       (bit_sel),
    .test_bit      (test_bit),
    .next_two_word (next_two_word),
    .out_vld       (out_vld),
    .next_pc       (next_pc),
    .push_en       (push_en),
    .push_addr     (push_addr),
    .cycles        (cycles),
    .set_ie        (set_ie)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  initial begin
    wait (cyc_cnt > 150000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog expired: got %0d cycles, expected fewer than 150000", cyc_cnt);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // expected results from the requirements
  logic [15:0] e_pc;
  logic        e_push;
  logic [15:0] e_paddr;
  logic [2:0]  e_cyc;
  logic        e_ie;
  string       e_req;

  task automatic model();
    logic [15:0] ext12;
    logic [15:0] ext7;
    logic        sb;
    ext12   = {{4{rel_off[11]}}, rel_off};
    ext7    = {{9{rel_off[6]}}, rel_off[6:0]};
    sb      = sreg[bit_sel];
    e_pc    = pc + 16'd1;
    e_push  = 1'b0;
    e_paddr = 16'd0;
    e_cyc   = 3'd1;
    e_ie    = 1'b0;
    e_req   = "R10";
    case (op)
      4'd1: begin e_pc = pc + ext12 + 16'd1; e_cyc = 3'd2; e_req = "R3"; end
      4'd2: begin e_pc = z_ptr; e_cyc = 3'd2; e_req = "R4"; end
      4'd3: begin e_pc = abs_tgt; e_cyc = 3'd3; e_req = "R5"; end
      4'd4: begin e_pc = pc + ext12 + 16'd1; e_cyc = 3'd3; e_push = 1'b1;
                  e_paddr = pc + 16'd1; e_req = "R3/R6"; end
      4'd5: begin e_pc = z_ptr; e_cyc = 3'd3; e_push = 1'b1;
                  e_paddr = pc + 16'd1; e_req = "R4/R6"; end
      4'd6: begin e_pc = abs_tgt; e_cyc = 3'd4; e_push = 1'b1;
                  e_paddr = pc + 16'd2; e_req = "R5/R6"; end
      4'd7: begin e_pc = pop_addr; e_cyc = 3'd4; e_req = "R7"; end
      4'd8: begin e_pc = pop_addr; e_cyc = 3'd4; e_ie = 1'b1; e_req = "R7"; end
      4'd9, 4'd10: begin
        e_req = "R8";
        if ((op == 4'd10) == test_bit) begin
          e_pc  = next_two_word ? pc + 16'd3 : pc + 16'd2;
          e_cyc = next_two_word ? 3'd3 : 3'd2;
        end
      end
      4'd11, 4'd12: begin
        e_req = "R9";
        if ((op == 4'd12) == sb) begin
          e_pc  = pc + ext7 + 16'd1;
          e_cyc = 3'd2;
        end
      end
      default: e_req = "R10";
    endcase
  endtask

  task automatic check_out(input string req, input logic x_vld, input logic [15:0] x_pc,
                           input logic x_push, input logic [15:0] x_pa,
                           input logic [2:0] x_cyc, input logic x_ie);
    n_tests = n_tests + 1;
    if (out_vld !== x_vld || next_pc !== x_pc || push_en !== x_push ||
        push_addr !== x_pa || cycles !== x_cyc || set_ie !== x_ie) begin
      n_fail = n_fail + 1;
      $display("FAIL %s op=%0d pc=%h: got vld=%b pc=%h push=%b pa=%h cyc=%0d ie=%b, expected vld=%b pc=%h push=%b pa=%h cyc=%0d ie=%b",
               req, op, pc, out_vld, next_pc, push_en, push_addr, cycles, set_ie,
               x_vld, x_pc, x_push, x_pa, x_cyc, x_ie);
    end
  endtask

  // drive at a falling edge, accept at the rising edge, check at the next falling edge (R11)
  task automatic do_step();
    step_en = 1'b1;
    model();
    @(posedge clk);
    @(negedge clk);
    check_out({e_req, "/R11"}, 1'b1, e_pc, e_push, e_paddr, e_cyc, e_ie);
  endtask

  logic [15:0] pc_set [4]  = '{16'h0000, 16'h0001, 16'h7FF0, 16'hFFFF};
  logic [11:0] off_set [6] = '{12'h000, 12'h001, 12'hFFF, 12'h03F, 12'hFC0, 12'h800};
  logic [7:0]  sr_set [3]  = '{8'h00, 8'hFF, 8'hA5};

  initial begin
    n_tests = 0; n_fail = 0; cyc_cnt = 0;
    rst_n = 1'b0; step_en = 1'b0; op = 4'd0; pc = 16'd0; rel_off = 12'd0;
    abs_tgt = 16'd0; z_ptr = 16'd0; pop_addr = 16'd0; sreg = 8'd0;
    bit_sel = 3'd0; test_bit = 1'b0; next_two_word = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_out("R1", 1'b0, 16'd0, 1'b0, 16'd0, 3'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1", 1'b0, 16'd0, 1'b0, 16'd0, 3'd0, 1'b0);

    // R9: branch-if-equal / branch-if-not-equal on the zero flag (bit 1)
    pc = 16'h0100; rel_off = 12'h005; bit_sel = 3'd1; sreg = 8'h02; op = 4'd12;
    do_step();
    check_out("R9 breq taken", 1'b1, 16'h0106, 1'b0, 16'd0, 3'd2, 1'b0);
    op = 4'd11;
    do_step();
    check_out("R9 brne not taken", 1'b1, 16'h0101, 1'b0, 16'd0, 3'd1, 1'b0);

    // R2: idle cycles keep the last result while inputs change
    step_en = 1'b0; op = 4'd8; pc = 16'h5555; pop_addr = 16'h1234;
    @(posedge clk); @(negedge clk);
    check_out("R2", 1'b0, 16'h0101, 1'b0, 16'd0, 3'd1, 1'b0);
    op = 4'd6; pc = 16'hFFFF; abs_tgt = 16'h4242;
    @(posedge clk); @(negedge clk);
    check_out("R2", 1'b0, 16'h0101, 1'b0, 16'd0, 3'd1, 1'b0);

    // R3..R10: sweep of codes, PCs, offsets, status patterns, bit selects, conditions
    for (int o = 0; o < 16; o++) begin
      for (int p = 0; p < 4; p++) begin
        for (int f = 0; f < 6; f++) begin
          for (int s = 0; s < 3; s++) begin
            for (int b = 0; b < 8; b++) begin
              for (int t = 0; t < 2; t++) begin
                for (int w = 0; w < 2; w++) begin
                  op = 4'(o); pc = pc_set[p]; rel_off = off_set[f];
                  sreg = sr_set[s]; bit_sel = 3'(b); test_bit = t[0];
                  next_two_word = w[0];
                  z_ptr = pc_set[p] ^ 16'h5A5A; abs_tgt = ~pc_set[p];
                  pop_addr = pc_set[p] + 16'h0100;
                  do_step();
                end
              end
            end
          end
        end
      end
    end

    // R2: one more idle check after an interrupt return result
    op = 4'd8; pc = 16'h0010; pop_addr = 16'h0777;
    do_step();
    step_en = 1'b0; op = 4'd4;
    @(posedge clk); @(negedge clk);
    check_out("R2/R7", 1'b0, 16'h0777, 1'b0, 16'd0, 3'd4, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule